// File: doc/BRIEF.md
# Sleep and Wake Power Handshake Controller

This block moves a processor between running and a low-power state. A sleep request arrives from the instruction stream, either as a wait-for-interrupt or as a block. A depth field from the sleep control register chooses what that request does. Depth zero makes the request a no-op. A shallow depth only stops the core clock. A deep depth also drops a power-up request toward an external power controller and waits for that controller to release its acknowledge.

Waking reverses the sequence. The controller raises the clock enable, raises the power-up request if it had dropped it, and waits for the acknowledge. Only then does it permit bus access again. When no power controller exists, the acknowledge is wired straight back to the request, and every exchange still completes.

An unblock pulse from outside releases a block that is waiting. If no block is waiting, the pulse is remembered, and the next block completes at once. A separate strobe from executed unblock instructions is re-timed into a one-cycle pulse for other cores. The controller runs on the always-on clock. The clock-enable output drives an external gate on the core clock.

States: RUN (request high, clock on), REQ_DROP (request low, waiting for the acknowledge to go low), ASLEEP (clock enable low), WAKE_REQ (request high, clock on, waiting for the acknowledge to go high).

Transitions:
- RUN to REQ_DROP: a deep sleep request.
- RUN to ASLEEP: a shallow sleep request.
- RUN to RUN: a request that falls through.
- REQ_DROP to ASLEEP: the acknowledge is low.
- ASLEEP to WAKE_REQ: a wake condition.
- WAKE_REQ to RUN: the acknowledge is high.

Top module: `pwr_sleep_ctrl`

## Requirements
- R1: After the asynchronous active-low reset, the state is RUN. `pwr_req` and `clk_gate_en` are high, and `bus_ok` follows `pwr_ack`.
- R2: In RUN, a sleep request with `sleep_depth` of 2 or more (deep) enters REQ_DROP.
  - In REQ_DROP, `pwr_req` is low, `clk_gate_en` stays high and `bus_ok` is low.
  - The controller stays in REQ_DROP until `pwr_ack` is low, then enters ASLEEP.
- R3: In ASLEEP, `clk_gate_en` is low and `bus_ok` is low. After a deep entry, `pwr_req` stays low there.
- R4: A wake condition in ASLEEP leads to WAKE_REQ. In WAKE_REQ, `pwr_req` and `clk_gate_en` are high and `bus_ok` is low. The controller stays in WAKE_REQ until `pwr_ack` is high, then returns to RUN.
- R5: A sleep request with `sleep_depth` equal to 1 (shallow) goes straight to ASLEEP. `pwr_req` stays high throughout the sleep and the wake.
- R6: `clk_gate_en` is high for at least one full cycle before `bus_ok` can rise. This allows one cycle of delay in the external clock gate.
- R7: A sleep request falls through and leaves the state in RUN in either of these cases:
  - `sleep_depth` is 0;
  - `wake_evt` is high in the request cycle.
- R8: A block (`sleep_is_blk` = 1) leaves ASLEEP on an `unblock_in` pulse or on `wake_evt`. A wait-for-interrupt (`sleep_is_blk` = 0) leaves ASLEEP only on `wake_evt`.
- R9: An `unblock_in` pulse that releases no waiting block is held as pending. The next block then falls through, and that block consumes the pending flag.
- R10: An `unblock_in` pulse in the same cycle as a block request makes that block fall through and leaves nothing pending.
- R11: `unblock_out` is high for exactly the cycle after a cycle in which `unblock_exec` was high while in RUN. It stays low otherwise.
- R12: `bus_ok` is high only in RUN, and only while both `pwr_req` and `pwr_ack` are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| aon_clk | input | 1 | Always-on clock, never gated |
| rst_n | input | 1 | Asynchronous active-low reset |
| sleep_req | input | 1 | One-cycle request to enter sleep |
| sleep_is_blk | input | 1 | 1 = block request, 0 = wait-for-interrupt |
| sleep_depth | input | DEPTH_W | 0 = no sleep, 1 = shallow, 2 or more = deep |
| wake_evt | input | 1 | Level wake event (pending interrupt) |
| unblock_in | input | 1 | External unblock pulse |
| unblock_exec | input | 1 | Strobe: an unblock instruction executed |
| pwr_ack | input | 1 | Power-up acknowledge from the power controller |
| pwr_req | output | 1 | Power-up request |
| clk_gate_en | output | 1 | Enable for the external core clock gate |
| bus_ok | output | 1 | Bus access permitted |
| unblock_out | output | 1 | One-cycle unblock pulse to other cores |

## Verification
Two functions can fall in the same cycle: the arrival of an external unblock pulse and a block request. The unblock pulse would normally set the pending flag, and the block would normally consume it.

The bench drives both inputs in one cycle and expects the controller to stay in RUN. It then issues a second block with no pulse and expects that block to sleep, which proves nothing was left pending. The bench also drives a block whose release is the pending flag set many cycles earlier, and it runs the deep handshake both with a tied-back acknowledge and with an acknowledge held off for extra cycles.

// File: rtl/pwr_sleep_pkg.sv
package pwr_sleep_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_REQ_DROP = 2'd1,
        ST_ASLEEP   = 2'd2,
        ST_WAKE_REQ = 2'd3
    } slp_state_e;
endpackage

// File: rtl/pwr_unblk_latch.sv
// Holds an unblock pulse that no waiting block has consumed yet.
module pwr_unblk_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic unblock_in,
    input  logic blk_done,
    output logic unblk_pend
);
    logic pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pend_q <= 1'b0;
        else if (blk_done)
            pend_q <= 1'b0;
        else if (unblock_in)
            pend_q <= 1'b1;
    end

    assign unblk_pend = pend_q;
endmodule

// File: rtl/pwr_unblk_pulse.sv
// Re-times the executed-unblock strobe into a registered pulse, only while running.
module pwr_unblk_pulse
    import pwr_sleep_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       unblock_exec,
    input  slp_state_e state,
    output logic       unblock_out
);
    logic pulse_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            pulse_q <= 1'b0;
        else
            pulse_q <= unblock_exec && (state == ST_RUN);
    end

    assign unblock_out = pulse_q;
endmodule

// File: rtl/pwr_sleep_fsm.sv
module pwr_sleep_fsm
    import pwr_sleep_pkg::*;
#(
    parameter int DEPTH_W  = 2,
    parameter int DEEP_MIN = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               sleep_is_blk,
    input  logic [DEPTH_W-1:0] sleep_depth,
    input  logic               wake_evt,
    input  logic               unblock_in,
    input  logic               unblk_pend,
    input  logic               pwr_ack,
    output slp_state_e         state,
    output logic               blk_done,
    output logic               pwr_req,
    output logic               clk_gate_en,
    output logic               bus_ok
);
    localparam logic [DEPTH_W-1:0] DEEP_LVL = DEPTH_W'(DEEP_MIN);

    slp_state_e state_q, state_d;
    logic       deep_q, deep_d;
    logic       blk_q, blk_d;
    logic       release_now, pass_thru, go_deep;

    assign release_now = unblk_pend | unblock_in;
    assign pass_thru   = (sleep_depth == '0) | wake_evt | (sleep_is_blk & release_now);
    assign go_deep     = (sleep_depth >= DEEP_LVL);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            deep_q  <= 1'b0;
            blk_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            deep_q  <= deep_d;
            blk_q   <= blk_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        deep_d   = deep_q;
        blk_d    = blk_q;
        blk_done = 1'b0;
        unique case (state_q)
            ST_RUN: begin
                if (sleep_req) begin
                    if (pass_thru) begin
                        blk_done = sleep_is_blk;
                    end else begin
                        blk_d   = sleep_is_blk;
                        deep_d  = go_deep;
                        state_d = go_deep ? ST_REQ_DROP : ST_ASLEEP;
                    end
                end
            end
            ST_REQ_DROP: begin
                if (!pwr_ack)
                    state_d = ST_ASLEEP;
            end
            ST_ASLEEP: begin
                if (wake_evt | (blk_q & release_now)) begin
                    state_d  = ST_WAKE_REQ;
                    blk_done = blk_q;
                end
            end
            ST_WAKE_REQ: begin
                if (pwr_ack)
                    state_d = ST_RUN;
            end
            default: state_d = ST_RUN;
        endcase
    end

    always_comb begin
        pwr_req     = 1'b1;
        clk_gate_en = 1'b1;
        bus_ok      = 1'b0;
        unique case (state_q)
            ST_RUN:      bus_ok = pwr_ack;
            ST_REQ_DROP: pwr_req = 1'b0;
            ST_ASLEEP: begin
                pwr_req     = !deep_q;
                clk_gate_en = 1'b0;
            end
            ST_WAKE_REQ: bus_ok = 1'b0;
            default:     bus_ok = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/pwr_sleep_ctrl.sv
module pwr_sleep_ctrl
    import pwr_sleep_pkg::*;
#(
    parameter int DEPTH_W  = 2,
    parameter int DEEP_MIN = 2
) (
    input  logic               aon_clk,
    input  logic               rst_n,
    input  logic               sleep_req,
    input  logic               sleep_is_blk,
    input  logic [DEPTH_W-1:0] sleep_depth,
    input  logic               wake_evt,
    input  logic               unblock_in,
    input  logic               unblock_exec,
    input  logic               pwr_ack,
    output logic               pwr_req,
    output logic               clk_gate_en,
    output logic               bus_ok,
    output logic               unblock_out
);
    slp_state_e state;
    logic       blk_done;
    logic       unblk_pend;

    pwr_unblk_latch u_latch (
        .clk        (aon_clk),
        .rst_n      (rst_n),
        .unblock_in (unblock_in),
        .blk_done   (blk_done),
        .unblk_pend (unblk_pend)
    );

    pwr_sleep_fsm #(
        .DEPTH_W  (DEPTH_W),
        .DEEP_MIN (DEEP_MIN)
    ) u_fsm (
        .clk          (aon_clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sleep_is_blk (sleep_is_blk),
        .sleep_depth  (sleep_depth),
        .wake_evt     (wake_evt),
        .unblock_in   (unblock_in),
        .unblk_pend   (unblk_pend),
        .pwr_ack      (pwr_ack),
        .state        (state),
        .blk_done     (blk_done),
        .pwr_req      (pwr_req),
        .clk_gate_en  (clk_gate_en),
        .bus_ok       (bus_ok)
    );

    pwr_unblk_pulse u_pulse (
        .clk          (aon_clk),
        .rst_n        (rst_n),
        .unblock_exec (unblock_exec),
        .state        (state),
        .unblock_out  (unblock_out)
    );
endmodule

// File: rtl/pwr_sleep_ctrl_chk.sv
module pwr_sleep_ctrl_chk (
    input logic aon_clk,
    input logic rst_n,
    input logic unblock_exec,
    input logic pwr_ack,
    input logic pwr_req,
    input logic clk_gate_en,
    input logic bus_ok,
    input logic unblock_out
);
    AST_BUS_NEEDS_HANDSHAKE: assert property (@(posedge aon_clk) disable iff (!rst_n)
        bus_ok |-> (pwr_req && pwr_ack)); // R12
    AST_GATED_NO_BUS: assert property (@(posedge aon_clk) disable iff (!rst_n)
        !clk_gate_en |-> !bus_ok); // R3
    AST_CLK_BEFORE_BUS: assert property (@(posedge aon_clk) disable iff (!rst_n)
        $rose(clk_gate_en) |-> !bus_ok); // R6
    AST_DROP_WITH_CLOCK: assert property (@(posedge aon_clk) disable iff (!rst_n)
        $fell(pwr_req) |-> (clk_gate_en && !bus_ok)); // R2
    AST_WAKE_WAITS_ACK: assert property (@(posedge aon_clk) disable iff (!rst_n)
        $rose(pwr_req) |-> !bus_ok); // R4
    AST_UNBLOCK_FROM_EXEC: assert property (@(posedge aon_clk) disable iff (!rst_n)
        unblock_out |-> $past(unblock_exec)); // R11
endmodule

bind pwr_sleep_ctrl pwr_sleep_ctrl_chk u_chk (
    .aon_clk      (aon_clk),
    .rst_n        (rst_n),
    .unblock_exec (unblock_exec),
    .pwr_ack      (pwr_ack),
    .pwr_req      (pwr_req),
    .clk_gate_en  (clk_gate_en),
    .bus_ok       (bus_ok),
    .unblock_out  (unblock_out)
);

// File: tb/pwr_sleep_ctrl_tb.sv
module pwr_sleep_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sleep_req = 1'b0, sleep_is_blk = 1'b0;
    logic [1:0] sleep_depth = 2'd0;
    logic       wake_evt = 1'b0, unblock_in = 1'b0, unblock_exec = 1'b0;
    logic       tie = 1'b1, ack_drv = 1'b1;
    logic       pwr_ack, pwr_req, clk_gate_en, bus_ok, unblock_out;
    logic [3:0] exp_q[$];
    string      tag_q[$];
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    // {pwr_req, clk_gate_en, bus_ok, unblock_out}
    localparam logic [3:0] E_RUN  = 4'b1110;
    localparam logic [3:0] E_DROP = 4'b0100;
    localparam logic [3:0] E_DEEP = 4'b0000;
    localparam logic [3:0] E_SHAL = 4'b1000;
    localparam logic [3:0] E_WAKE = 4'b1100;

    always #10 clk = ~clk;

    assign pwr_ack = tie ? pwr_req : ack_drv;

    pwr_sleep_ctrl u_dut (
        .aon_clk      (clk),
        .rst_n        (rst_n),
        .sleep_req    (sleep_req),
        .sleep_is_blk (sleep_is_blk),
        .sleep_depth  (sleep_depth),
        .wake_evt     (wake_evt),
        .unblock_in   (unblock_in),
        .unblock_exec (unblock_exec),
        .pwr_ack      (pwr_ack),
        .pwr_req      (pwr_req),
        .clk_gate_en  (clk_gate_en),
        .bus_ok       (bus_ok),
        .unblock_out  (unblock_out)
    );

    // Driver: applies one cycle of stimulus and queues the outputs expected after the edge.
    task automatic step(input string tag, input logic sr, input logic blk, input logic [1:0] dep,
                        input logic wk, input logic ui, input logic ue, input logic ad,
                        input logic [3:0] exp);
        @(negedge clk);
        sleep_req = sr; sleep_is_blk = blk; sleep_depth = dep;
        wake_evt = wk; unblock_in = ui; unblock_exec = ue; ack_drv = ad;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
    endtask

    // Monitor: pops one expectation per cycle, a quarter period after the edge.
    always @(posedge clk) begin
        #5;
        if (exp_q.size() > 0) begin
            logic [3:0] e, got;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            got = {pwr_req, clk_gate_en, bus_ok, unblock_out};
            checks++;
            if (got !== e) begin
                errors++;
                $display("FAIL %s actual=%b expected=%b", t, got, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        step("R1 reset state",            0,0,2'd0,0,0,0,1, E_RUN);
        step("R2 deep entry drops req",   1,0,2'd2,0,0,0,1, E_DROP);
        step("R3 deep asleep",            0,0,2'd0,0,0,0,1, E_DEEP);
        step("R11 no pulse while asleep", 0,0,2'd0,0,0,1,1, E_DEEP);
        step("R4 wake raises req",        0,0,2'd0,1,0,0,1, E_WAKE);
        step("R4 ack returns to run",     0,0,2'd0,0,0,0,1, E_RUN);
        step("R5 shallow keeps req",      1,0,2'd1,0,0,0,1, E_SHAL);
        step("R8 wfi ignores unblock",    0,0,2'd0,0,1,0,1, E_SHAL);
        step("R6 clock before bus",       0,0,2'd0,1,0,0,1, E_WAKE);
        step("R6 bus after clock",        0,0,2'd0,0,0,0,1, E_RUN);
        step("R9 block pend from wfi",    1,1,2'd1,0,0,0,1, E_RUN);
        step("R7 depth zero no sleep",    1,0,2'd0,0,0,0,1, E_RUN);
        step("R7 wake pending no sleep",  1,0,2'd2,1,0,0,1, E_RUN);
        step("R8 block sleeps",           1,1,2'd1,0,0,0,1, E_SHAL);
        step("R8 block waits",            0,0,2'd0,0,0,0,1, E_SHAL);
        step("R8 unblock releases",       0,0,2'd0,0,1,0,1, E_WAKE);
        step("R8 back to run",            0,0,2'd0,0,0,0,1, E_RUN);
        step("R9 unblock held",           0,0,2'd0,0,1,0,1, E_RUN);
        step("R9 idle with pend",         0,0,2'd0,0,0,0,1, E_RUN);
        step("R9 block falls through",    1,1,2'd2,0,0,0,1, E_RUN);
        step("R9 pend consumed",          1,1,2'd1,0,0,0,1, E_SHAL);
        step("R8 wake frees block",       0,0,2'd0,1,0,0,1, E_WAKE);
        step("R8 run again",              0,0,2'd0,0,0,0,1, E_RUN);
        step("R10 same cycle unblock",    1,1,2'd2,0,1,0,1, E_RUN);
        step("R10 nothing left pending",  1,1,2'd2,0,0,0,1, E_DROP);
        step("R10 deep block asleep",     0,0,2'd0,0,0,0,1, E_DEEP);
        step("R10 unblock wakes deep",    0,0,2'd0,0,1,0,1, E_WAKE);
        step("R10 run",                   0,0,2'd0,0,0,0,1, E_RUN);
        step("R11 unblock pulse",         0,0,2'd0,0,0,1,1, 4'b1111);
        step("R11 pulse one cycle",       0,0,2'd0,0,0,0,1, E_RUN);
        @(negedge clk);
        tie = 1'b0;
        step("R2 drop with ack high",     1,0,2'd3,0,0,0,1, E_DROP);
        step("R2 waits for ack low",      0,0,2'd0,0,0,0,1, E_DROP);
        step("R2 ack low enters sleep",   0,0,2'd0,0,0,0,0, E_DEEP);
        step("R4 wake with ack low",      0,0,2'd0,1,0,0,0, E_WAKE);
        step("R4 waits for ack high",     0,0,2'd0,0,0,0,0, E_WAKE);
        step("R4 ack high runs",          0,0,2'd0,0,0,0,1, E_RUN);
        step("R12 ack low blocks bus",    0,0,2'd0,0,0,0,0, 4'b1100);
        step("R12 ack high allows bus",   0,0,2'd0,0,0,0,1, E_RUN);
        step("R12 idle",                  0,0,2'd0,0,0,0,1, E_RUN);
        repeat (3) @(negedge clk);
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule